// File: doc/BRIEF.md
# Force-Feedback Sensor Phase Sequencer

This block produces the repeating switch-control schedule for a capacitive sensor that is held in place by one-bit electrostatic force feedback. Every loop cycle is divided into five phases in a fixed order: feedback, zero, positive sense, negative sense and compare. In each phase the block drives the enables of the analog switches. These switches clamp and release the charge integrator, the input common-mode feedback amplifier, the proof mass, the sense electrodes and the holding capacitors. The block also drives the proof-mass pulse polarity and two strobes: one for the compensator sample and one for the comparator latch.

A single proof-mass pulse schedule serves several axis channels. Each axis has its own comparator bit. The bit is captured by the latch strobe and sets which stationary electrode of that axis gets the reference voltage in the next feedback phase. The bit is also sent out as a one-bit stream with a valid strobe, once per cycle. Phase lengths are given in master-clock counts. The feedback phase is derived so that it takes one quarter of the period. A programmable guard gap keeps any switch that closes at a phase boundary open for a few clocks after the boundary.

Top module: `forceLoopSequencer`

## Requirements
- R1: The phases repeat in the order feedback, zero first half, zero second half, positive sense, negative sense, compare. The lengths are ZERO_LEN/2, ZERO_LEN-ZERO_LEN/2, SENSE_A_LEN, SENSE_B_LEN and CMP_LEN clocks, so one cycle is 4*FB_LEN clocks and successive compensator strobes are exactly that far apart.
- R2: The feedback phase lasts FB_LEN = (ZERO_LEN+SENSE_A_LEN+SENSE_B_LEN+CMP_LEN)/3 clocks, one quarter of the cycle. Feedback drive is active for FB_LEN-NOV_GAP of those clocks.
- R3: While feedback drive is active, these outputs are all high: intInGnd, intOutShort, cmfbOutGnd and massGnd. elecToInt is low, which isolates the electrodes.
- R4: During active feedback drive, each axis drives exactly one of fbHiRef and fbLoRef. It drives fbHiRef when its last latched comparator bit is 1 and fbLoRef when it is 0. Neither output changes within one feedback phase.
- R5: In the first half of zero, elecGnd is high and elecToInt is low. In the second half, elecToInt is high while intInGnd, intOutShort, cmfbOutGnd and massGnd stay high.
- R6: intInGnd, intOutShort, cmfbOutGnd and massGnd all fall in the first clock of the positive sense phase.
- R7: In the positive sense phase, pulsePos and holdGnd are high. In the negative sense phase, pulseNeg is high and holdGnd is low. elecToInt stays high from the zero second half through compare.
- R8: compSample is high for one clock, the last clock of the negative sense phase. cmpLatch is high for one clock, at offset NOV_GAP within the compare phase.
- R9: A switch that is off in the preceding phase and on in the current one stays open for the first NOV_GAP (at least 1) clocks of the current phase. As a result, pulsePos/pulseNeg, elecGnd/elecToInt, feedback drive/elecGnd and massGnd/either pulse are never high together, and neither of a pair is high in the clock right after the other.
- R10: A synchronous reset forces every output low and restarts the sequence at the first clock of feedback. All latched bits clear to 0.
- R11: On the clock edge that ends the cmpLatch clock, each axis captures its cmpIn bit. From the next clock, bitOut shows the captured bits and bitValid is high for that one clock. bitOut holds until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cmpIn | input | N_AXES | Comparator decision per axis |
| intInGnd | output | 1 | Ground the integrator inputs |
| intOutShort | output | 1 | Short the integrator outputs together |
| cmfbOutGnd | output | 1 | Ground the common-mode feedback amplifier output |
| massGnd | output | 1 | Ground the proof mass |
| elecGnd | output | 1 | Tie the sense capacitors to ground |
| elecToInt | output | 1 | Connect the sense electrodes to the integrator |
| holdGnd | output | 1 | Ground the holding capacitors |
| pulsePos | output | 1 | Apply the positive sense pulse to the proof mass |
| pulseNeg | output | 1 | Apply the negative sense pulse to the proof mass |
| fbHiRef | output | N_AXES | Reference voltage on the first stationary electrode, per axis |
| fbLoRef | output | N_AXES | Reference voltage on the second stationary electrode, per axis |
| compSample | output | 1 | Compensator sample strobe |
| cmpLatch | output | 1 | Comparator latch strobe |
| bitOut | output | N_AXES | Per-axis loop bit stream |
| bitValid | output | 1 | bitOut holds a new cycle's bits |

## Verification
The bench compares every output on every clock with a schedule computed from the phase lengths. It drives random comparator bits and also holds the comparator inputs all-one, all-zero and mixed for whole cycles.

The bench targets several corner cases. The first is the clock just after each boundary: a missing guard gap would close a switch while its partner is still closed. The second is the first positive-sense clock: if the releases are staggered, the integrator is left half clamped while the pulse starts. The third is the comparator value exactly at the latch edge: capturing one clock early or late would steer feedback to the wrong electrode. The last is a reset in the middle of a sense phase: if the sequence does not restart at feedback with every switch open, a pulse or stale bit would carry over.

// File: rtl/fbseqPkg.sv
package fbseqPkg;

  typedef enum logic [2:0] {
    SEG_FB  = 3'd0,
    SEG_Z1  = 3'd1,
    SEG_Z2  = 3'd2,
    SEG_SA  = 3'd3,
    SEG_SB  = 3'd4,
    SEG_CMP = 3'd5
  } seg_e;

  // Analog switch enables leaving the block directly.
  typedef struct packed {
    logic intInGnd;
    logic intOutShort;
    logic cmfbOutGnd;
    logic massGnd;
    logic elecGnd;
    logic elecToInt;
    logic holdGnd;
    logic pulsePos;
    logic pulseNeg;
  } sw_t;

  // Full request set of one segment, including the feedback drive.
  typedef struct packed {
    sw_t  pad;
    logic fbDrive;
  } req_t;

  // Strobes from control to the per-axis datapath.
  typedef struct packed {
    logic fbDrive;
    logic cmpLatch;
  } axisCtl_t;

  function automatic seg_e segNext(seg_e s);
    case (s)
      SEG_FB:  return SEG_Z1;
      SEG_Z1:  return SEG_Z2;
      SEG_Z2:  return SEG_SA;
      SEG_SA:  return SEG_SB;
      SEG_SB:  return SEG_CMP;
      default: return SEG_FB;
    endcase
  endfunction

  function automatic seg_e segPrev(seg_e s);
    case (s)
      SEG_FB:  return SEG_CMP;
      SEG_Z1:  return SEG_FB;
      SEG_Z2:  return SEG_Z1;
      SEG_SA:  return SEG_Z2;
      SEG_SB:  return SEG_SA;
      default: return SEG_SB;
    endcase
  endfunction

  // Switches that a segment wants closed, before guard gating.
  function automatic req_t segReq(seg_e s);
    req_t r;
    r = '0;
    case (s)
      SEG_FB: begin
        r.pad.intInGnd    = 1'b1;
        r.pad.intOutShort = 1'b1;
        r.pad.cmfbOutGnd  = 1'b1;
        r.pad.massGnd     = 1'b1;
        r.fbDrive         = 1'b1;
      end
      SEG_Z1: begin
        r.pad.intInGnd    = 1'b1;
        r.pad.intOutShort = 1'b1;
        r.pad.cmfbOutGnd  = 1'b1;
        r.pad.massGnd     = 1'b1;
        r.pad.elecGnd     = 1'b1;
      end
      SEG_Z2: begin
        r.pad.intInGnd    = 1'b1;
        r.pad.intOutShort = 1'b1;
        r.pad.cmfbOutGnd  = 1'b1;
        r.pad.massGnd     = 1'b1;
        r.pad.elecToInt   = 1'b1;
      end
      SEG_SA: begin
        r.pad.elecToInt = 1'b1;
        r.pad.pulsePos  = 1'b1;
        r.pad.holdGnd   = 1'b1;
      end
      SEG_SB: begin
        r.pad.elecToInt = 1'b1;
        r.pad.pulseNeg  = 1'b1;
      end
      default: begin
        r.pad.elecToInt = 1'b1;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fbseqCtrl.sv
module fbseqCtrl
  import fbseqPkg::*;
#(
  parameter int ZERO_LEN    = 8,
  parameter int SENSE_A_LEN = 6,
  parameter int SENSE_B_LEN = 6,
  parameter int CMP_LEN     = 4,
  parameter int NOV_GAP     = 1
) (
  input  logic     clk,
  input  logic     rst,
  output sw_t      swOut,
  output logic     compSample,
  output axisCtl_t axisCtl
);

  localparam int FB_LEN  = (ZERO_LEN + SENSE_A_LEN + SENSE_B_LEN + CMP_LEN) / 3;
  localparam int Z1_LEN  = ZERO_LEN / 2;
  localparam int Z2_LEN  = ZERO_LEN - Z1_LEN;
  localparam int MAX_AB  = (SENSE_A_LEN > SENSE_B_LEN) ? SENSE_A_LEN : SENSE_B_LEN;
  localparam int MAX_FZ  = (FB_LEN > Z2_LEN) ? FB_LEN : Z2_LEN;
  localparam int MAX_X   = (MAX_AB > CMP_LEN) ? MAX_AB : CMP_LEN;
  localparam int MAX_LEN = (MAX_FZ > MAX_X) ? MAX_FZ : MAX_X;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  seg_e             seg;
  logic [CNT_W-1:0] segCnt;
  logic [CNT_W-1:0] segLast;
  logic             segEnd;
  logic             pastGap;
  req_t             reqNow;
  req_t             reqPrev;
  req_t             gated;

  always_comb begin
    case (seg)
      SEG_FB:  segLast = CNT_W'(FB_LEN - 1);
      SEG_Z1:  segLast = CNT_W'(Z1_LEN - 1);
      SEG_Z2:  segLast = CNT_W'(Z2_LEN - 1);
      SEG_SA:  segLast = CNT_W'(SENSE_A_LEN - 1);
      SEG_SB:  segLast = CNT_W'(SENSE_B_LEN - 1);
      default: segLast = CNT_W'(CMP_LEN - 1);
    endcase
  end

  assign segEnd = (segCnt == segLast);

  always_ff @(posedge clk) begin
    if (rst) begin
      seg    <= SEG_FB;
      segCnt <= '0;
    end else if (segEnd) begin
      seg    <= segNext(seg);
      segCnt <= '0;
    end else begin
      segCnt <= segCnt + 1'b1;
    end
  end

  // A switch newly requested at a boundary waits out the guard gap;
  // one carried over from the previous segment stays closed.
  assign pastGap = (segCnt >= CNT_W'(NOV_GAP));
  assign reqNow  = segReq(seg);
  assign reqPrev = segReq(segPrev(seg));

  always_comb begin
    gated = reqNow & (reqPrev | {$bits(req_t){pastGap}});
    if (rst) gated = '0;
  end

  assign swOut            = gated.pad;
  assign axisCtl.fbDrive  = gated.fbDrive;
  assign axisCtl.cmpLatch = !rst && (seg == SEG_CMP) && (segCnt == CNT_W'(NOV_GAP));
  assign compSample       = !rst && (seg == SEG_SB) && segEnd;

  // R1: segments advance in the fixed order
  p_order_r1: assert property (@(posedge clk) disable iff (rst)
    segEnd |=> (seg == segNext($past(seg))));

  // R3: feedback drive only with the integrator clamped and electrodes isolated
  p_fb_isolate_r3: assert property (@(posedge clk) disable iff (rst)
    axisCtl.fbDrive |-> (swOut.intInGnd && swOut.intOutShort && swOut.cmfbOutGnd
                         && swOut.massGnd && !swOut.elecToInt));

  // R5: electrodes reach the integrator in zero only while clamps are closed
  p_zero_clamp_r5: assert property (@(posedge clk) disable iff (rst)
    (seg == SEG_Z2 && swOut.elecToInt) |-> (swOut.intInGnd && swOut.intOutShort));

  // R6: the four releases happen in the same clock
  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(swOut.intInGnd) |-> ($fell(swOut.massGnd) && $fell(swOut.cmfbOutGnd)
                               && $fell(swOut.intOutShort)));

  // R7: holding capacitors grounded on the positive pulse, released on the negative
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (swOut.pulsePos |-> swOut.holdGnd) and (swOut.pulseNeg |-> !swOut.holdGnd));

  // R8: compensator sample is a single clock that closes the negative pulse
  p_sample_r8: assert property (@(posedge clk) disable iff (rst)
    compSample |=> (!compSample && !swOut.pulseNeg));

  // R9: conflicting pairs never overlap and never touch back to back
  p_nov_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    swOut.pulseNeg |-> (!swOut.pulsePos && !$past(swOut.pulsePos)));
  p_nov_elec_r9: assert property (@(posedge clk) disable iff (rst)
    swOut.elecToInt |-> (!swOut.elecGnd && !$past(swOut.elecGnd)));
  p_nov_fb_r9: assert property (@(posedge clk) disable iff (rst)
    swOut.elecGnd |-> (!axisCtl.fbDrive && !$past(axisCtl.fbDrive)));
  p_nov_mass_r9: assert property (@(posedge clk) disable iff (rst)
    swOut.massGnd |-> (!swOut.pulsePos && !swOut.pulseNeg));

  // R10: reset restarts at the first feedback clock
  p_restart_r10: assert property (@(posedge clk)
    rst |=> (seg == SEG_FB && segCnt == '0));

endmodule

// File: rtl/fbseqAxes.sv
module fbseqAxes
  import fbseqPkg::*;
#(
  parameter int N_AXES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  axisCtl_t          axisCtl,
  input  logic [N_AXES-1:0] cmpIn,
  output logic [N_AXES-1:0] fbHiRef,
  output logic [N_AXES-1:0] fbLoRef,
  output logic [N_AXES-1:0] bitOut,
  output logic              bitValid
);

  always_ff @(posedge clk) begin
    if (rst) bitValid <= 1'b0;
    else     bitValid <= axisCtl.cmpLatch;
  end

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    logic bitQ;

    always_ff @(posedge clk) begin
      if (rst)                   bitQ <= 1'b0;
      else if (axisCtl.cmpLatch) bitQ <= cmpIn[a];
    end

    assign fbHiRef[a] = axisCtl.fbDrive &  bitQ;
    assign fbLoRef[a] = axisCtl.fbDrive & ~bitQ;
    assign bitOut[a]  = bitQ;

    // R4: the chosen electrode does not change inside one feedback phase
    p_fb_steady_r4: assert property (@(posedge clk) disable iff (rst)
      (axisCtl.fbDrive && $past(axisCtl.fbDrive)) |->
        ($stable(fbHiRef[a]) && $stable(fbLoRef[a])));

    // R11: the stream bit only moves right after a latch strobe
    p_bit_hold_r11: assert property (@(posedge clk) disable iff (rst)
      !$past(axisCtl.cmpLatch) |-> $stable(bitOut[a]));
  end

endmodule

// File: rtl/forceLoopSequencer.sv
module forceLoopSequencer
  import fbseqPkg::*;
#(
  parameter int N_AXES      = 3,
  parameter int ZERO_LEN    = 8,
  parameter int SENSE_A_LEN = 6,
  parameter int SENSE_B_LEN = 6,
  parameter int CMP_LEN     = 4,
  parameter int NOV_GAP     = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_AXES-1:0] cmpIn,
  output logic              intInGnd,
  output logic              intOutShort,
  output logic              cmfbOutGnd,
  output logic              massGnd,
  output logic              elecGnd,
  output logic              elecToInt,
  output logic              holdGnd,
  output logic              pulsePos,
  output logic              pulseNeg,
  output logic [N_AXES-1:0] fbHiRef,
  output logic [N_AXES-1:0] fbLoRef,
  output logic              compSample,
  output logic              cmpLatch,
  output logic [N_AXES-1:0] bitOut,
  output logic              bitValid
);

  sw_t      swBus;
  axisCtl_t axisCtl;

  fbseqCtrl #(
    .ZERO_LEN   (ZERO_LEN),
    .SENSE_A_LEN(SENSE_A_LEN),
    .SENSE_B_LEN(SENSE_B_LEN),
    .CMP_LEN    (CMP_LEN),
    .NOV_GAP    (NOV_GAP)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .swOut     (swBus),
    .compSample(compSample),
    .axisCtl   (axisCtl)
  );

  fbseqAxes #(
    .N_AXES(N_AXES)
  ) u_axes (
    .clk     (clk),
    .rst     (rst),
    .axisCtl (axisCtl),
    .cmpIn   (cmpIn),
    .fbHiRef (fbHiRef),
    .fbLoRef (fbLoRef),
    .bitOut  (bitOut),
    .bitValid(bitValid)
  );

  assign intInGnd    = swBus.intInGnd;
  assign intOutShort = swBus.intOutShort;
  assign cmfbOutGnd  = swBus.cmfbOutGnd;
  assign massGnd     = swBus.massGnd;
  assign elecGnd     = swBus.elecGnd;
  assign elecToInt   = swBus.elecToInt;
  assign holdGnd     = swBus.holdGnd;
  assign pulsePos    = swBus.pulsePos;
  assign pulseNeg    = swBus.pulseNeg;
  assign cmpLatch    = axisCtl.cmpLatch;

endmodule

// File: tb/forceLoopSequencer_test.sv
module forceLoopSequencer_test;

  localparam int NA  = 3;
  localparam int ZL  = 8;
  localparam int SAL = 6;
  localparam int SBL = 6;
  localparam int CL  = 4;
  localparam int G   = 1;
  localparam int FBL = (ZL + SAL + SBL + CL) / 3;
  localparam int SZ1 = FBL;
  localparam int SZ2 = SZ1 + ZL / 2;
  localparam int SSA = SZ1 + ZL;
  localparam int SSB = SSA + SAL;
  localparam int SCM = SSB + SBL;
  localparam int P   = SCM + CL;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NA-1:0] cmpIn = '0;
  logic intInGnd, intOutShort, cmfbOutGnd, massGnd, elecGnd, elecToInt;
  logic holdGnd, pulsePos, pulseNeg, compSample, cmpLatch, bitValid;
  logic [NA-1:0] fbHiRef, fbLoRef, bitOut;

  int checks = 0;
  int fails  = 0;
  int t      = 0;
  int lastSample = -1;
  int fbCount    = 0;
  int cycAbs     = 0;
  logic [NA-1:0] expBit = '0;

  always #4 clk = ~clk;

  forceLoopSequencer #(
    .N_AXES(NA), .ZERO_LEN(ZL), .SENSE_A_LEN(SAL), .SENSE_B_LEN(SBL),
    .CMP_LEN(CL), .NOV_GAP(G)
  ) uut (
    .clk(clk), .rst(rst), .cmpIn(cmpIn),
    .intInGnd(intInGnd), .intOutShort(intOutShort), .cmfbOutGnd(cmfbOutGnd),
    .massGnd(massGnd), .elecGnd(elecGnd), .elecToInt(elecToInt),
    .holdGnd(holdGnd), .pulsePos(pulsePos), .pulseNeg(pulseNeg),
    .fbHiRef(fbHiRef), .fbLoRef(fbLoRef), .compSample(compSample),
    .cmpLatch(cmpLatch), .bitOut(bitOut), .bitValid(bitValid)
  );

  // Expected {clamps x4, elecGnd, elecToInt, holdGnd, pulsePos, pulseNeg}
  function automatic logic [8:0] expSw(int pos);
    logic clampOn, eGnd, eInt, pPos, pNeg;
    clampOn = (pos >= G) && (pos < SSA);
    eGnd    = (pos >= SZ1 + G) && (pos < SZ2);
    eInt    = (pos >= SZ2 + G);
    pPos    = (pos >= SSA + G) && (pos < SSB);
    pNeg    = (pos >= SSB + G) && (pos < SCM);
    return {clampOn, clampOn, clampOn, clampOn, eGnd, eInt, pPos, pPos, pNeg};
  endfunction

  function automatic logic expFb(int pos);
    return (pos >= G) && (pos < SZ1);
  endfunction

  function automatic logic expLatch(int pos);
    return pos == SCM + G;
  endfunction

  function automatic string tagFor(int pos);
    if (pos == SSA) return "R6";
    if (pos < G || (pos >= SZ1 && pos < SZ1 + G) || (pos >= SZ2 && pos < SZ2 + G) ||
        (pos > SSA && pos < SSA + G) || (pos >= SSB && pos < SSB + G))
      return "R9";
    if (pos < SZ1) return "R3";
    if (pos < SSA) return "R5";
    return "R7";
  endfunction

  task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s pos=%0d got=%h exp=%h", tag, what, t % P, got, exp);
    end
  endtask

  task automatic checkAll(int pos);
    logic [8:0] gotSw;
    logic       fb;
    gotSw = {intInGnd, intOutShort, cmfbOutGnd, massGnd, elecGnd, elecToInt,
             holdGnd, pulsePos, pulseNeg};
    fb = expFb(pos);
    chk(tagFor(pos), "switches", 16'(gotSw), 16'(expSw(pos)));
    chk("R4", "fbHi/fbLo", 16'({fbHiRef, fbLoRef}),
        16'({fb ? expBit : '0, fb ? ~expBit : '0}));
    chk("R8", "strobes", 16'({compSample, cmpLatch}),
        16'({pos == SCM - 1, expLatch(pos)}));
    chk("R11", "stream", 16'({bitValid, bitOut}),
        16'({pos == SCM + G + 1, expBit}));
    if (fbHiRef != 0 || fbLoRef != 0) fbCount++;
    if (compSample) begin
      if (lastSample >= 0) chk("R1", "cycle length", 16'(cycAbs - lastSample), 16'(P));
      chk("R2", "feedback clocks", 16'(fbCount + G), 16'(P / 4));
      lastSample = cycAbs;
      fbCount    = 0;
    end
  endtask

  task automatic checkReset();
    chk("R10", "reset outputs",
        16'({intInGnd, intOutShort, cmfbOutGnd, massGnd, elecGnd, elecToInt,
             holdGnd, pulsePos, pulseNeg, compSample, cmpLatch, bitValid}), 16'h0);
    chk("R10", "reset axes", 16'({fbHiRef, fbLoRef, bitOut}), 16'h0);
  endtask

  // mode 0 random, 1 all ones, 2 all zeros, 3 pattern 101
  task automatic drive(int mode, int pos);
    case (mode)
      1:       cmpIn = '1;
      2:       cmpIn = '0;
      3:       cmpIn = 3'b101;
      default: cmpIn = NA'($urandom);
    endcase
    if (expLatch(pos)) expBit = cmpIn;
  endtask

  task automatic startRun(int mode);
    rst = 1'b0;
    t = 0;
    expBit = '0;
    lastSample = -1;
    fbCount = 0;
    #1;
    checkAll(0);
    drive(mode, 0);
  endtask

  task automatic runCycles(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      t++;
      cycAbs++;
      checkAll(t % P);
      drive(mode, t % P);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) begin
      @(negedge clk);
      checkReset();
    end
    startRun(0);
    runCycles(6 * P, 0);
    runCycles(2 * P, 1);
    runCycles(2 * P, 2);
    runCycles(2 * P, 3);
    runCycles(P + SSA + 3 - (t % P), 0);
    // reset in the middle of a positive pulse
    @(negedge clk);
    rst = 1'b1;
    cycAbs++;
    repeat (2) begin
      @(negedge clk);
      cycAbs++;
      checkReset();
    end
    startRun(0);
    runCycles(6 * P, 0);
    runCycles(P, 3);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule